// File: doc/BRIEF.md
# Multiplexed External-Bus Port

This block is an eight-pin port that either serves as plain general-purpose I/O or hands its pins to the upper byte of an external memory bus. Software sets, per pin, an output latch value, a direction bit and two function bits. Together these decide whether the pin is plain I/O, a data or address/data line, or an address-only line.

The bus flavour is fixed by a strap input sampled while reset is held. A low strap gives separate-bus use, where the pins carry data bits 8 to 15. A high strap gives multiplexed use, where the pins carry address/data or address bits 8 to 15. A stop request removes every pin driver whatever the registers hold. The driver enable and driver value of each pin come from flops, so the pads never see a combinational glitch. The bus controller's timing and the pad electricals sit outside this block.

Top module: `muxbus_port`

## Requirements
- R1: While `rst_n` is low, the latch, direction and both function registers clear to 0. `pin_oe` is 0 on the first edge of reset and afterwards.
- R2: `mux_mode` takes the level of `strap_mux` on the last clock edge with `rst_n` low. It then ignores `strap_mux` until the next reset.
- R3: A pin whose function bits are both 0 is plain I/O. With direction 1 it drives `pin_oe`=1 and `pin_out` = latch bit. With direction 0 its `pin_oe` is 0.
- R4: A read with `rd_sel`=0 returns, per bit: the pin level if direction is 0, the latch if the pin is plain I/O with direction 1, and the pin level for a bus-role pin.
- R5: Function A set with function B clear and direction 1 gives the data role in either mode: `pin_oe` follows `bus_ad_oe` and `pin_out` follows `bus_ad_out`.
- R6: Function B set with direction 1 in multiplexed mode gives the address role: `pin_oe` follows `bus_ad_oe` and `pin_out` follows `bus_addr_out`. Function B wins over function A.
- R7: In separate mode, a pin with function B set has its driver off (`pin_oe`=0, `pin_out`=0).
- R8: `stop_req` high on a clock edge forces every `pin_oe` bit to 0 from that edge. The register contents are not changed, and drivers return one edge after `stop_req` falls.
- R9: `bus_rd_data` equals `pin_in` combinationally, whatever the configuration.
- R10: A write with `wr_en` high updates on that edge the register chosen by `wr_sel` (0 latch, 1 direction, 2 function A, 3 function B). `rd_sel` values 1 to 3 read the same registers back.
- R11: `pin_oe` and `pin_out` are flops. They change one edge after the registers or bus inputs that feed them, and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mux | input | 1 | Bus-mode strap, sampled while in reset (1 = multiplexed) |
| stop_req | input | 1 | Stop condition; disables all drivers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 latch, 1 direction, 2 function A, 3 function B |
| wr_data | input | W | Write data |
| rd_sel | input | 2 | Read source: 0 port, 1 direction, 2 function A, 3 function B |
| rd_data | output | W | Read data |
| mux_mode | output | 1 | Latched strap (1 = multiplexed mode) |
| bus_ad_out | input | W | Bus controller data or address/data byte |
| bus_addr_out | input | W | Bus controller address-only byte |
| bus_ad_oe | input | 1 | Bus controller output enable |
| bus_rd_data | output | W | Pin levels for bus reads |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Pad output values (registered) |
| pin_oe | output | W | Pad driver enables (registered) |

## Verification
A stop request and a register write that turns drivers on can arrive on the same edge. The bench raises `stop_req` in the cycle that writes all direction bits to 1. It then expects `pin_oe` to read 0 while the direction read-back already shows the new value. Once stop falls, the drivers must come up from the register contents. Bus-role pins and plain I/O pins also share a single read of the port. The bench mixes the roles within one byte and checks that each bit returns the latch or the pin level as its role requires.

// File: rtl/bp_pkg.sv
// Shared types for the multiplexed bus port.
// Assumes: register select and pin role encodings are fixed by the brief.
package bp_pkg;
    typedef enum logic [1:0] {
        SEL_LATCH = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_FNA   = 2'd2,
        SEL_FNB   = 2'd3
    } bp_sel_e;

    typedef enum logic [1:0] {
        ROLE_GPIO = 2'd0,
        ROLE_DATA = 2'd1,
        ROLE_ADDR = 2'd2,
        ROLE_OFF  = 2'd3
    } bp_role_e;

    // Decodes one pin's role from its function bits and the bus mode.
    function automatic bp_role_e role_of(input logic fna, input logic fnb, input logic mux);
        if (fnb)      return mux ? ROLE_ADDR : ROLE_OFF;
        else if (fna) return ROLE_DATA;
        else          return ROLE_GPIO;
    endfunction
endpackage

// File: rtl/bp_regs.sv
// Register file of the port: output latch, direction, two function
// registers, plus the bus-mode strap latch.
// Assumes: synchronous active-low reset; the strap is stable in reset.
module bp_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_mux,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] fna_q,
    output logic [W-1:0] fnb_q,
    output logic         mux_mode_q
);
    import bp_pkg::*;

    // Register writes; all cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            fna_q   <= '0;
            fnb_q   <= '0;
        end else if (wr_en) begin
            case (bp_sel_e'(wr_sel))
                SEL_LATCH: latch_q <= wr_data;
                SEL_DIR:   dir_q   <= wr_data;
                SEL_FNA:   fna_q   <= wr_data;
                SEL_FNB:   fnb_q   <= wr_data;
                default:   ;
            endcase
        end
    end

    // Strap tracks while in reset, frozen once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) mux_mode_q <= strap_mux;
    end
endmodule

// File: rtl/bp_pin_slice.sv
// One pin: decodes its role, registers driver enable and driver value,
// and forms the port read bit.
// Assumes: bus inputs are synchronous to clk.
module bp_pin_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic mux_mode,
    input  logic latch_b,
    input  logic dir_b,
    input  logic fna_b,
    input  logic fnb_b,
    input  logic ad_b,
    input  logic addr_b,
    input  logic ad_oe,
    input  logic pin_in_b,
    output logic pin_oe_b,
    output logic pin_out_b,
    output logic rd_b
);
    import bp_pkg::*;

    bp_role_e role;
    logic     oe_nx;
    logic     dat_nx;

    // Next driver enable and value from the role.
    always_comb begin
        role   = role_of(fna_b, fnb_b, mux_mode);
        oe_nx  = 1'b0;
        dat_nx = 1'b0;
        case (role)
            ROLE_GPIO: begin oe_nx = dir_b;         dat_nx = latch_b; end
            ROLE_DATA: begin oe_nx = dir_b & ad_oe; dat_nx = ad_b;    end
            ROLE_ADDR: begin oe_nx = dir_b & ad_oe; dat_nx = addr_b;  end
            default:   begin oe_nx = 1'b0;          dat_nx = 1'b0;    end
        endcase
        if (stop_req) oe_nx = 1'b0;
    end

    // Glitch-free pad drive flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_oe_b  <= 1'b0;
            pin_out_b <= 1'b0;
        end else begin
            pin_oe_b  <= oe_nx;
            pin_out_b <= dat_nx;
        end
    end

    // Port read: latch only for plain outputs, pin level otherwise.
    always_comb rd_b = (dir_b && role == ROLE_GPIO) ? latch_b : pin_in_b;
endmodule

// File: rtl/bp_readback.sv
// Read-data selector across the port bits and the configuration registers.
// Assumes: combinational read, encoding shared with writes except 0 = port.
module bp_readback #(
    parameter int W = 8
) (
    input  logic [1:0]   rd_sel,
    input  logic [W-1:0] port_rd,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] fna_q,
    input  logic [W-1:0] fnb_q,
    output logic [W-1:0] rd_data
);
    import bp_pkg::*;

    // Selects the read source.
    always_comb begin
        case (bp_sel_e'(rd_sel))
            SEL_DIR: rd_data = dir_q;
            SEL_FNA: rd_data = fna_q;
            SEL_FNB: rd_data = fnb_q;
            default: rd_data = port_rd;
        endcase
    end
endmodule

// File: rtl/muxbus_port.sv
// Top of the multiplexed external-bus port: register file, one slice per
// pin, and the read selector.
// Assumes: synchronous active-low reset; bus controller timing is external.
module muxbus_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_mux,
    input  logic         stop_req,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         mux_mode,
    input  logic [W-1:0] bus_ad_out,
    input  logic [W-1:0] bus_addr_out,
    input  logic         bus_ad_oe,
    output logic [W-1:0] bus_rd_data,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    logic [W-1:0] latch_q, dir_q, fna_q, fnb_q, port_rd;

    bp_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_mux(strap_mux),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .latch_q(latch_q), .dir_q(dir_q), .fna_q(fna_q), .fnb_q(fnb_q),
        .mux_mode_q(mux_mode)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        bp_pin_slice u_slice (
            .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mux_mode(mux_mode),
            .latch_b(latch_q[i]), .dir_b(dir_q[i]), .fna_b(fna_q[i]), .fnb_b(fnb_q[i]),
            .ad_b(bus_ad_out[i]), .addr_b(bus_addr_out[i]), .ad_oe(bus_ad_oe),
            .pin_in_b(pin_in[i]), .pin_oe_b(pin_oe[i]), .pin_out_b(pin_out[i]),
            .rd_b(port_rd[i])
        );
    end

    bp_readback #(.W(W)) u_rd (
        .rd_sel(rd_sel), .port_rd(port_rd), .dir_q(dir_q),
        .fna_q(fna_q), .fnb_q(fnb_q), .rd_data(rd_data)
    );

    // External bus reads see the pads directly.
    assign bus_rd_data = pin_in;
endmodule

// File: rtl/muxbus_port_chk.sv
// Property checker for muxbus_port, bound into every instance.
// Assumes: sees the top's ports and its register outputs.
module muxbus_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         stop_req,
    input logic         mux_mode,
    input logic         bus_ad_oe,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] fna_q,
    input logic [W-1:0] fnb_q,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_out
);
    p_reset_off_r1: assert property (@(posedge clk) !rst_n |=> pin_oe == '0);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mux_mode));

    p_dir_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_oe & ~$past(dir_q)) == '0);

    p_gpio_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_out ^ $past(latch_q)) & $past(~fna_q & ~fnb_q)) == '0);

    p_bus_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ad_oe |=> (pin_oe & $past(fna_q | fnb_q)) == '0);

    p_sep_addr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_mode |=> (pin_oe & $past(fnb_q)) == '0);

    p_stop_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> pin_oe == '0);
endmodule

bind muxbus_port muxbus_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mux_mode(mux_mode),
    .bus_ad_oe(bus_ad_oe), .latch_q(latch_q), .dir_q(dir_q),
    .fna_q(fna_q), .fnb_q(fnb_q), .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/muxbus_port_tb.sv
`timescale 1ns/1ps
module muxbus_port_tb;
    localparam int W = 8;

    logic clk = 1'b0, rst_n = 1'b0, strap_mux = 1'b1, stop_req = 1'b0;
    logic wr_en = 1'b0, bus_ad_oe = 1'b0;
    logic [1:0] wr_sel = '0, rd_sel = '0;
    logic [W-1:0] wr_data = '0, bus_ad_out = '0, bus_addr_out = '0, pin_in = '0;
    logic [W-1:0] rd_data, bus_rd_data, pin_out, pin_oe;
    logic mux_mode;

    always #2.5 clk = ~clk;

    muxbus_port #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_mux(strap_mux), .stop_req(stop_req),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .mux_mode(mux_mode), .bus_ad_out(bus_ad_out),
        .bus_addr_out(bus_addr_out), .bus_ad_oe(bus_ad_oe),
        .bus_rd_data(bus_rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Scoreboard item: which output, expected value, requirement tag.
    typedef struct {
        string      tag;
        int         what;   // 0 pin_oe, 1 pin_out, 2 rd_data, 3 mux_mode, 4 bus_rd_data
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_vec = 0, n_bad = 0;
    bit    done = 1'b0;

    function automatic logic [7:0] observe(input int what);
        case (what)
            0: return pin_oe;
            1: return pin_out;
            2: return rd_data;
            3: return {7'd0, mux_mode};
            default: return bus_rd_data;
        endcase
    endfunction

    // Monitor: pops expected items and compares with the live outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = observe(it.what);
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: signal %0d actual %h expected %h", it.tag, it.what, act, it.exp);
                end
            end
        end
    end

    // Driver side: push one expectation and wait for it to be judged.
    task automatic expect_v(input string tag, input int what, input logic [7:0] exp);
        item_t it;
        it.tag = tag; it.what = what; it.exp = exp;
        q.push_back(it);
        -> chk_ev;
        wait (q.size() == 0);
    endtask

    task automatic expect_rd(input string tag, input logic [1:0] s, input logic [7:0] exp);
        rd_sel = s;
        #0.5;
        expect_v(tag, 2, exp);
        rd_sel = 2'd0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; strap_mux = strap;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap_mux = ~strap;   // later strap changes must be ignored
    endtask

    initial begin
        // ---- Multiplexed mode ----
        do_reset(1'b1);
        expect_v("R1 oe after reset", 0, 8'h00);
        expect_rd("R1 dir cleared", 2'd1, 8'h00);
        expect_rd("R1 fnA cleared", 2'd2, 8'h00);
        expect_rd("R1 fnB cleared", 2'd3, 8'h00);
        expect_v("R2 strap high held", 3, 8'h01);
        pin_in = 8'h5A;
        expect_rd("R4 inputs read pins", 2'd0, 8'h5A);

        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h0F);
        @(negedge clk);
        expect_v("R3 gpio oe", 0, 8'h0F);
        expect_v("R3 gpio out", 1, 8'hA5);
        expect_rd("R4 mixed in/out read", 2'd0, 8'h55);
        expect_rd("R10 dir readback", 2'd1, 8'h0F);

        bus_ad_out = 8'h81; bus_addr_out = 8'h48; bus_ad_oe = 1'b1;
        wr(2'd2, 8'h0B);
        wr(2'd3, 8'h0C);
        @(negedge clk);
        expect_v("R5 R6 bus roles oe", 0, 8'h0F);
        expect_v("R5 R6 bus roles out, fnB priority", 1, 8'hA9);
        expect_rd("R4 bus pins read pins", 2'd0, 8'h5A);
        expect_rd("R10 fnB readback", 2'd3, 8'h0C);
        expect_rd("R10 fnA readback", 2'd2, 8'h0B);

        bus_ad_oe = 1'b0;
        @(negedge clk);
        expect_v("R5 bus oe gates driver", 0, 8'h00);
        bus_ad_oe = 1'b1;
        @(negedge clk);
        expect_v("R6 bus oe restores", 0, 8'h0F);

        // Stop and a direction write on the same edge.
        stop_req = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        expect_v("R8 stop wins over write", 0, 8'h00);
        expect_rd("R10 write lands under stop", 2'd1, 8'hFF);
        @(negedge clk);
        expect_v("R8 stop holds", 0, 8'h00);
        stop_req = 1'b0;
        @(negedge clk);
        expect_v("R8 drivers return", 0, 8'hFF);
        expect_v("R8 out from registers", 1, 8'hA9);

        pin_in = 8'hC6;
        #0.5;
        expect_v("R9 bus read follows pins", 4, 8'hC6);

        @(negedge clk);
        bus_ad_out = 8'h82;
        #1;
        expect_v("R11 no change before edge", 1, 8'hA9);
        @(negedge clk);
        expect_v("R11 change after edge", 1, 8'hAA);

        // ---- Separate mode ----
        do_reset(1'b0);
        expect_v("R2 strap low held", 3, 8'h00);
        expect_v("R1 oe after second reset", 0, 8'h00);
        expect_rd("R1 fnB cleared again", 2'd3, 8'h00);
        bus_ad_out = 8'h55;
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h0F);
        wr(2'd3, 8'hF0);
        @(negedge clk);
        expect_v("R7 addr role off in separate mode", 0, 8'h0F);
        expect_v("R5 R7 separate-mode data", 1, 8'h05);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule